// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the sync, blanking and data-enable signals that drive a parallel RGB display panel. Software programs the lengths of the sync pulse, back porch, active region and front porch for each axis through a small register port, then sets a run bit. A horizontal counter steps once per pixel-enable strobe and a vertical counter steps once per completed line. The current line count is available both as an output and as a readable register.

Each line and each frame is laid out as sync pulse first, then back porch, then the active region, then front porch. Every length field holds its count minus one, so a field of zero means one pixel or one line. The timing fields are copied into a working set only while the generator is stopped or at the last pixel of a frame. A write in the middle of a frame therefore cannot distort the frame already being scanned.

A frame interrupt marks one chosen line boundary in each frame. It latches a pending bit only when both a global enable and a frame enable are set. Software clears the pending bit by writing one to it.

Top module: `rtg_top`

## Requirements
- R1: After reset, hsync, vsync, de and irq are low, hblank and vblank are high, line_no is 0, and every register reads 0.
- R2: While running, each line is hsync for HSW+1 pixel strobes, then HBP+1 strobes of back porch, then HACT+1 active strobes, then HFP+1 strobes of front porch. hblank is low only in the active part. Sync is active-high. The horizontal count starts at 0 at the sync start.
- R3: Lines follow the same order using VSW+1, VBP+1, VACT+1 and VFP+1 lines. vsync and line_no change only at the end of a line. line_no is the line count from the vsync start.
- R4: de is high exactly when both the horizontal and the vertical position lie in their active parts.
- R5: Both counters and all video outputs hold their values in any cycle without a pixel-enable strobe.
- R6: Timing fields written while running take effect only from the frame that follows the last pixel of the current frame. While stopped they take effect at once.
- R7: Control bit 0 (run) cleared forces sync and de low and blanking high, and holds both counters at 0. Setting it starts a frame at the hsync and vsync start.
- R8: Control bits 4:3 select the interrupt line boundary, evaluated as the vertical count enters a line: 0 = vsync start (line 0), 1 = first active line, 2 = first front-porch line, 3 = threshold line.
- R9: The pending bit (irq) sets on the selected event only when control bit 1 (global enable) and bit 2 (frame enable) are both 1.
- R10: Writing 1 to bit 0 at address 1 clears the pending bit. If an event occurs in the same cycle, the set wins. Writing 0 has no effect.
- R11: The register map is: 0 control, 1 pending status, 2 to 5 HSW/HBP/HACT/HFP, 6 to 9 VSW/VBP/VACT/VFP, 10 threshold, 11 line count (read-only). Fields read back as written.
- R12: With select 3, the event fires as the vertical count enters line VSW+VBP+2+THR. This is active line THR, so THR = VACT marks the last active line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel strobe; counters advance only when high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Combinational read data for reg_addr |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |
| hblank | output | 1 | High outside the horizontal active part |
| vblank | output | 1 | High outside the vertical active part |
| de | output | 1 | Data enable |
| line_no | output | CW+2 (14) | Current vertical count |
| irq | output | 1 | Frame interrupt pending |

## Verification
Some properties are checked on every cycle. These are: outputs and line_no stay frozen between pixel strobes; vsync and line_no stay frozen within a line; counters are held at zero while stopped; the pending bit rises only with both enables set; a clear write drops it when no event competes; and events occur only at line ends.

Other behaviour needs the bench's reference model over whole frames. This covers the exact lengths and order of every porch, de placement, and the deferral of mid-frame timing writes to the next frame. It also covers where each interrupt select fires, including the threshold line, under random strobe rates and random field values.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int NFIELD  = 9;
   localparam int F_HSW   = 0;
   localparam int F_HBP   = 1;
   localparam int F_HACT  = 2;
   localparam int F_HFP   = 3;
   localparam int F_VSW   = 4;
   localparam int F_VBP   = 5;
   localparam int F_VACT  = 6;
   localparam int F_VFP   = 7;
   localparam int F_THR   = 8;

   localparam int A_CTRL   = 0;
   localparam int A_STAT   = 1;
   localparam int A_FIELD0 = 2;
   localparam int A_LINE   = A_FIELD0 + NFIELD;

   typedef enum logic [1:0] {
      TRG_VSYNC  = 2'd0,
      TRG_ACTIVE = 2'd1,
      TRG_FPORCH = 2'd2,
      TRG_THRESH = 2'd3
   } rtg_trig_e;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile import rtg_pkg::*; #(
   parameter int DW = 32,
   parameter int AW = 4,
   parameter int CW = 12,
   parameter int LW = CW + 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [AW-1:0]                addr,
   input  logic [DW-1:0]                wdata,
   input  logic                         pend,
   input  logic [LW-1:0]                line_no,
   output logic [DW-1:0]                rdata,
   output logic                         en_q,
   output logic                         gie_q,
   output logic                         fie_q,
   output rtg_trig_e                    sel_q,
   output logic                         clr_pend,
   output logic [NFIELD-1:0][CW-1:0]    fld_q
);
   logic unused_wdata;
   assign unused_wdata = ^wdata[DW-1:CW];

   assign clr_pend = we && (addr == AW'(A_STAT)) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         gie_q <= 1'b0;
         fie_q <= 1'b0;
         sel_q <= TRG_VSYNC;
         fld_q <= '0;
      end else if (we) begin
         if (addr == AW'(A_CTRL)) begin
            en_q  <= wdata[0];
            gie_q <= wdata[1];
            fie_q <= wdata[2];
            sel_q <= rtg_trig_e'(wdata[4:3]);
         end
         for (int i = 0; i < NFIELD; i++) begin
            if (addr == AW'(A_FIELD0 + i)) fld_q[i] <= wdata[CW-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(A_CTRL)) rdata[4:0] = {sel_q, fie_q, gie_q, en_q};
      if (addr == AW'(A_STAT)) rdata[0] = pend;
      if (addr == AW'(A_LINE)) rdata[LW-1:0] = line_no;
      for (int i = 0; i < NFIELD; i++) begin
         if (addr == AW'(A_FIELD0 + i)) rdata[CW-1:0] = fld_q[i];
      end
   end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
   parameter int CW = 12,
   parameter int LW = CW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [CW-1:0] sync_m1,
   input  logic [CW-1:0] back_m1,
   input  logic [CW-1:0] act_m1,
   input  logic [CW-1:0] front_m1,
   output logic [LW-1:0] cnt,
   output logic [LW-1:0] nxt,
   output logic          last,
   output logic          in_sync,
   output logic          in_act,
   output logic [LW-1:0] act_start,
   output logic [LW-1:0] fp_start
);
   logic [LW-1:0] sync_end;
   logic [LW-1:0] last_idx;

   assign sync_end  = LW'(sync_m1) + LW'(1);
   assign act_start = sync_end + LW'(back_m1) + LW'(1);
   assign fp_start  = act_start + LW'(act_m1) + LW'(1);
   assign last_idx  = fp_start + LW'(front_m1);

   assign last    = (cnt == last_idx);
   assign nxt     = last ? '0 : cnt + LW'(1);
   assign in_sync = (cnt < sync_end);
   assign in_act  = (cnt >= act_start) && (cnt < fp_start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (step)  cnt <= nxt;
   end
endmodule

// File: rtl/rtg_irq.sv
module rtg_irq import rtg_pkg::*; #(
   parameter int CW = 12,
   parameter int LW = CW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_step,
   input  logic [LW-1:0] v_nxt,
   input  rtg_trig_e     sel,
   input  logic [LW-1:0] act_start,
   input  logic [LW-1:0] fp_start,
   input  logic [CW-1:0] thr,
   input  logic          gie,
   input  logic          fie,
   input  logic          clr,
   output logic          evt,
   output logic          pend
);
   logic [LW-1:0] target;

   always_comb begin
      unique case (sel)
         TRG_VSYNC:  target = '0;
         TRG_ACTIVE: target = act_start;
         TRG_FPORCH: target = fp_start;
         default:    target = act_start + LW'(thr);
      endcase
   end

   assign evt = v_step && (v_nxt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend <= 1'b0;
      else if (evt && gie && fie) pend <= 1'b1;
      else if (clr)               pend <= 1'b0;
   end
endmodule

// File: rtl/rtg_top.sv
module rtg_top import rtg_pkg::*; #(
   parameter int DW        = 32,
   parameter int AW        = 4,
   parameter int CW        = 12,
   parameter bit SHADOW_EN = 1'b1,
   localparam int LW       = CW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_en,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          hsync,
   output logic          vsync,
   output logic          hblank,
   output logic          vblank,
   output logic          de,
   output logic [LW-1:0] line_no,
   output logic          irq
);
   if (CW < 2) begin : g_bad_cw
      $error("rtg_top: CW must be at least 2");
   end
   if (AW < 4) begin : g_bad_aw
      $error("rtg_top: AW must be at least 4");
   end
   if (DW < LW) begin : g_bad_dw
      $error("rtg_top: DW must hold the line count");
   end

   logic                      en_q, gie_q, fie_q, clr_pend, irq_evt;
   rtg_trig_e                 sel_q;
   logic [NFIELD-1:0][CW-1:0] fld_q, shd;
   logic                      shd_load;
   logic                      h_step, h_last, h_sync, h_act;
   logic                      v_step, v_last, v_sync, v_act;
   logic [LW-1:0]             h_cnt, v_cnt, v_nxt, v_act_start, v_fp_start;
   logic [LW-1:0]             h_nxt_unused, h_as_unused, h_fs_unused;

   rtg_regfile #(.DW(DW), .AW(AW), .CW(CW), .LW(LW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .pend(irq), .line_no(v_cnt), .rdata(reg_rdata), .en_q(en_q), .gie_q(gie_q),
      .fie_q(fie_q), .sel_q(sel_q), .clr_pend(clr_pend), .fld_q(fld_q)
   );

   assign shd_load = !en_q || (v_step && v_last);

   if (SHADOW_EN) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        shd <= '0;
         else if (shd_load) shd <= fld_q;
      end
   end else begin : g_live
      logic unused_load;
      assign unused_load = shd_load;
      assign shd = fld_q;
   end

   assign h_step = en_q && pix_en;
   assign v_step = h_step && h_last;

   rtg_axis #(.CW(CW), .LW(LW)) u_hax (
      .clk(clk), .rst_n(rst_n), .clear(!en_q), .step(h_step),
      .sync_m1(shd[F_HSW]), .back_m1(shd[F_HBP]), .act_m1(shd[F_HACT]), .front_m1(shd[F_HFP]),
      .cnt(h_cnt), .nxt(h_nxt_unused), .last(h_last), .in_sync(h_sync), .in_act(h_act),
      .act_start(h_as_unused), .fp_start(h_fs_unused)
   );

   rtg_axis #(.CW(CW), .LW(LW)) u_vax (
      .clk(clk), .rst_n(rst_n), .clear(!en_q), .step(v_step),
      .sync_m1(shd[F_VSW]), .back_m1(shd[F_VBP]), .act_m1(shd[F_VACT]), .front_m1(shd[F_VFP]),
      .cnt(v_cnt), .nxt(v_nxt), .last(v_last), .in_sync(v_sync), .in_act(v_act),
      .act_start(v_act_start), .fp_start(v_fp_start)
   );

   rtg_irq #(.CW(CW), .LW(LW)) u_irq (
      .clk(clk), .rst_n(rst_n), .v_step(v_step), .v_nxt(v_nxt), .sel(sel_q),
      .act_start(v_act_start), .fp_start(v_fp_start), .thr(shd[F_THR]),
      .gie(gie_q), .fie(fie_q), .clr(clr_pend), .evt(irq_evt), .pend(irq)
   );

   assign hsync   = en_q && h_sync;
   assign vsync   = en_q && v_sync;
   assign hblank  = !(en_q && h_act);
   assign vblank  = !(en_q && v_act);
   assign de      = en_q && h_act && v_act;
   assign line_no = v_cnt;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker import rtg_pkg::*; #(
   parameter int AW = 4,
   parameter int CW = 12,
   parameter int LW = CW + 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pix_en,
   input logic          reg_we,
   input logic [AW-1:0] reg_addr,
   input logic          wr_bit0,
   input logic          hsync,
   input logic          vsync,
   input logic          de,
   input logic          irq,
   input logic [LW-1:0] line_no,
   input logic          en_q,
   input logic          gie_q,
   input logic          fie_q,
   input logic          irq_evt,
   input logic          v_step
);
   AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !pix_en && !reg_we) |=> ($stable(hsync) && $stable(vsync) && $stable(de) && $stable(line_no))); // R5
   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !reg_we && !v_step) |=> ($stable(vsync) && $stable(line_no))); // R3
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !reg_we) |=> (line_no == '0 && !hsync && !vsync && !de)); // R7
   AST_EVT_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt |-> v_step); // R8
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(gie_q && fie_q)); // R9
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(A_STAT) && wr_bit0 && !irq_evt) |=> !irq); // R10
endmodule

bind rtg_top rtg_checker #(.AW(AW), .CW(CW), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .reg_we(reg_we), .reg_addr(reg_addr),
   .wr_bit0(reg_wdata[0]), .hsync(hsync), .vsync(vsync), .de(de), .irq(irq),
   .line_no(line_no), .en_q(en_q), .gie_q(gie_q), .fie_q(fie_q), .irq_evt(irq_evt),
   .v_step(v_step)
);

// File: tb/sim_rtg_top.sv
`timescale 1ns/1ps
module sim_rtg_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_en = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        hsync, vsync, hblank, vblank, de, irq;
   logic [13:0] line_no;

   int n_chk = 0;
   int n_err = 0;
   int pe_pct = 0;
   bit mon_on = 1'b0;

   int m_h, m_v, m_sel;
   bit m_en, m_gie, m_fie, m_pend;
   int live [9];
   int shd  [9];

   always #2 clk = ~clk;

   rtg_top u0 (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
      .hblank(hblank), .vblank(vblank), .de(de), .line_no(line_no), .irq(irq)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(posedge clk); #1;
      reg_addr = 4'(a);
      @(negedge clk);
      v = int'(reg_rdata);
   endtask

   function automatic int fld_rand(input int i);
      if (i == 2) return int'($urandom % 8);
      if (i == 6 || i == 8) return int'($urandom % 6);
      return int'($urandom % 4);
   endfunction

   // reference model, stepped from the requirements
   always @(posedge clk) begin
      int htm1, vtm1, nv, tgt, vb2;
      bit ev, ld;
      ev = 1'b0; ld = 1'b0;
      if (!rst_n) begin
         m_h = 0; m_v = 0; m_en = 0; m_gie = 0; m_fie = 0; m_sel = 0; m_pend = 0;
         for (int i = 0; i < 9; i++) begin live[i] = 0; shd[i] = 0; end
      end else begin
         htm1 = shd[0] + shd[1] + shd[2] + shd[3] + 3;
         vtm1 = shd[4] + shd[5] + shd[6] + shd[7] + 3;
         if (!m_en) begin
            m_h = 0; m_v = 0; ld = 1'b1;
         end else if (pix_en) begin
            if (m_h == htm1) begin
               m_h = 0;
               nv = (m_v == vtm1) ? 0 : m_v + 1;
               if (m_v == vtm1) ld = 1'b1;
               vb2 = shd[4] + shd[5] + 2;
               case (m_sel)
                  0: tgt = 0;
                  1: tgt = vb2;
                  2: tgt = vb2 + shd[6] + 1;
                  default: tgt = vb2 + shd[8];
               endcase
               ev = (nv == tgt);
               m_v = nv;
            end else begin
               m_h = m_h + 1;
            end
         end
         if (ev && m_gie && m_fie) m_pend = 1'b1;
         else if (reg_we && reg_addr == 4'd1 && reg_wdata[0]) m_pend = 1'b0;
         if (ld) for (int i = 0; i < 9; i++) shd[i] = live[i];
         if (reg_we) begin
            if (reg_addr == 4'd0) begin
               m_en = reg_wdata[0]; m_gie = reg_wdata[1]; m_fie = reg_wdata[2];
               m_sel = int'(reg_wdata[4:3]);
            end else if (reg_addr >= 4'd2 && reg_addr <= 4'd10) begin
               live[int'(reg_addr) - 2] = int'(reg_wdata[11:0]);
            end
         end
      end
   end

   always @(negedge clk) begin
      int h1, h2, h3, v1, v2, v3;
      bit ehs, evs, eha, eva;
      string tg;
      if (rst_n && mon_on) begin
         h1 = shd[0] + 1; h2 = h1 + shd[1] + 1; h3 = h2 + shd[2] + 1;
         v1 = shd[4] + 1; v2 = v1 + shd[5] + 1; v3 = v2 + shd[6] + 1;
         ehs = m_en && (m_h < h1);
         eha = m_en && (m_h >= h2) && (m_h < h3);
         evs = m_en && (m_v < v1);
         eva = m_en && (m_v >= v2) && (m_v < v3);
         tg = m_en ? "" : " R7 stopped";
         check(hsync == ehs, {"R2 R5 R6 hsync", tg}, int'(hsync), int'(ehs));
         check(hblank == !eha, {"R2 hblank", tg}, int'(hblank), int'(!eha));
         check(vsync == evs, {"R3 vsync", tg}, int'(vsync), int'(evs));
         check(vblank == !eva, {"R3 vblank", tg}, int'(vblank), int'(!eva));
         check(int'(line_no) == m_v, {"R3 line_no", tg}, int'(line_no), m_v);
         check(de == (eha && eva), {"R4 de", tg}, int'(de), int'(eha && eva));
         check(irq == m_pend, "R8 R9 R10 R12 irq", int'(irq), int'(m_pend));
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk); #1;
         pix_en = (int'($urandom % 100) < pe_pct);
      end
   end

   task automatic run_cfg(input int cycles);
      int v, ctl;
      wr(0, 0);
      for (int i = 0; i < 9; i++) wr(2 + i, fld_rand(i));
      for (int i = 0; i < 9; i++) begin
         rd(2 + i, v);
         check(v == live[i], "R11 field readback", v, live[i]);
      end
      ctl = 1 | (int'($urandom % 4 != 0) << 1) | (int'($urandom % 4 != 0) << 2) | (int'($urandom % 4) << 3);
      wr(0, ctl);
      rd(0, v);
      check(v == ctl, "R11 control readback", v, ctl);
      pe_pct = 30 + int'($urandom % 71);
      for (int c = 0; c < cycles; c++) begin
         int r;
         r = int'($urandom % 64);
         if (r == 0) begin
            int k;
            k = int'($urandom % 9);
            wr(2 + k, fld_rand(k));          // R6 mid-frame write
         end else if (r == 1) begin
            wr(1, int'($urandom % 2));        // R10 clear or no-op
         end else if (r == 2) begin
            rd(11, v);
            check(v == m_v, "R11 line register", v, m_v);
         end else begin
            @(posedge clk);
         end
      end
   endtask

   initial begin
      int v;
      void'($urandom(32'd1357));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(hsync == 1'b0 && vsync == 1'b0, "R1 sync low", int'({hsync, vsync}), 0);
      check(hblank && vblank, "R1 blank high", int'({hblank, vblank}), 3);
      check(!de && !irq, "R1 de irq low", int'({de, irq}), 0);
      check(line_no == '0, "R1 line_no", int'(line_no), 0);
      check(reg_rdata == '0, "R1 control reads zero", int'(reg_rdata), 0);
      mon_on = 1'b1;

      // smallest frame, vsync-start interrupt
      pe_pct = 100;
      wr(0, 32'h7);
      repeat (60) @(posedge clk);
      pe_pct = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(irq == 1'b1, "R8 vsync-start event latched", int'(irq), 1);
      wr(1, 0);
      @(negedge clk);
      check(irq == 1'b1, "R10 writing zero keeps pending", int'(irq), 1);
      wr(1, 1);
      @(negedge clk);
      check(irq == 1'b0, "R10 write-one clears", int'(irq), 0);

      // R9: one enable alone never latches
      wr(0, 32'h3);
      pe_pct = 100;
      repeat (80) @(posedge clk);
      @(negedge clk);
      check(irq == 1'b0, "R9 global enable only", int'(irq), 0);
      wr(0, 32'h5);
      repeat (80) @(posedge clk);
      @(negedge clk);
      check(irq == 1'b0, "R9 frame enable only", int'(irq), 0);

      // R12 threshold on the last active line
      wr(0, 0);
      for (int i = 0; i < 8; i++) wr(2 + i, 1);
      wr(10, 1);
      wr(0, 32'h1F);
      pe_pct = 100;
      repeat (400) @(posedge clk);
      @(negedge clk);
      check(irq == 1'b1, "R12 threshold event", int'(irq), 1);

      for (int n = 0; n < 20; n++) run_cfg(2000);

      wr(0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(line_no == '0 && !hsync && !de, "R7 stopped idle", int'(line_no), 0);
      mon_on = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule